// File: doc/BRIEF.md
# Auto-Incrementing Register Block Access Port

This block gives a bus master, usually a DMA engine, a single fixed host location through which a whole bank of timer registers can be written or read. An internal 5-bit pointer names the low address bits of the target register. Each transfer through the access location goes out on a generic target strobe interface at that address. The pointer then steps to the next member of a fixed, gapped address walk. The walk has 18 members: 0x02, 0x03, 0x08 through 0x0F, and 0x18 through 0x1F. After 0x1F it returns to 0x02. The upper target address bits come from a parameter and never change.

Software can load the pointer and read it back through a second host location. A loaded value that is not on the walk is raised to the nearest member at or above it. A master that loads 0x02 and then moves 18 bytes through the access location reprograms the whole timer bank. It ends with the pointer back at 0x02, ready for the next block.

A timer request input is passed on as a DMA request only while the DMA destination address equals the access location.

Top module: `blkacc_port`

## Requirements
- R1: While and after synchronous reset, the pointer holds 0x02 and tgt_wr, tgt_rd, hst_rvalid and dma_req are low.
- R2: A host write at ACC_ADDR causes, one cycle later, a single-cycle tgt_wr pulse with tgt_wdata equal to the written data and tgt_addr at the pointer value seen in the request cycle; tgt_rd stays low.
- R3: A host read at ACC_ADDR causes a single-cycle tgt_rd pulse one cycle later at the current pointer address. Two cycles after the request, hst_rvalid is high for one cycle and hst_rdata carries the tgt_rdata sampled during the tgt_rd cycle.
- R4: Every access transfer, read or write, advances the pointer along 0x02, 0x03, 0x08..0x0F, 0x18..0x1F and wraps from 0x1F to 0x02. A transfer in the very next cycle already uses the advanced pointer.
- R5: A host write at PTR_ADDR loads the pointer from hst_wdata bits 4:0, raised to the smallest walk member at or above that value (0x00/0x01 go to 0x02, 0x04..0x07 to 0x08, 0x10..0x17 to 0x18). It issues no target strobe and takes effect in the next cycle.
- R6: A host read at PTR_ADDR returns, two cycles later with hst_rvalid, the pointer value of the request cycle zero-extended in hst_rdata. It issues no target strobe and leaves the pointer unchanged.
- R7: tgt_addr bits above bit 4 always equal the matching bits of TGT_BASE.
- R8: dma_req is high exactly one cycle after a cycle in which tmr_req is high and dma_dst equals ACC_ADDR.
- R9: Host strobes at any address other than ACC_ADDR and PTR_ADDR produce no target strobe and no hst_rvalid, and leave the pointer unchanged.
- R10: When hst_we and hst_re are both high in one cycle, only the write is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_addr | input | HAW | Host address |
| hst_we | input | 1 | Host write strobe |
| hst_re | input | 1 | Host read strobe |
| hst_wdata | input | DW | Host write data |
| hst_rdata | output | DW | Host read data |
| hst_rvalid | output | 1 | Host read data valid |
| tgt_addr | output | TAW | Target register address |
| tgt_wr | output | 1 | Target write strobe |
| tgt_rd | output | 1 | Target read strobe |
| tgt_wdata | output | DW | Target write data |
| tgt_rdata | input | DW | Target read data, valid while tgt_rd is high |
| tmr_req | input | 1 | Timer transfer request |
| dma_dst | input | HAW | Current DMA destination address |
| dma_req | output | 1 | Gated DMA request |

## Verification
Several events can share a clock edge. A new access can be taken while the previous access is still driving its target strobe. A pointer read can arrive directly after an access, and its pipeline stage then overlaps the read-data return of that access. The bench drives back-to-back access reads and writes with pointer reads and loads placed between them, and sweeps across the 0x1F wrap. Every clock it compares strobes, addresses and returned data against a behavioural model of the walk and a two-stage return queue. The DMA request gate is toggled during those same transfers, so routing is checked while data traffic is running.

// File: rtl/blkacc_pkg.sv
package blkacc_pkg;
  localparam int PTR_W = 5;
  localparam int PTR_N = 1 << PTR_W;
  localparam logic [PTR_W-1:0] WALK_FIRST = 5'h02;
  localparam logic [PTR_W-1:0] WALK_LAST  = 5'h1F;

  function automatic logic on_walk(input logic [PTR_W-1:0] p);
    return (p == 5'h02) || (p == 5'h03) || p[3];
  endfunction

  // smallest walk member >= v
  function automatic logic [PTR_W-1:0] walk_ceil(input logic [PTR_W-1:0] v);
    logic [PTR_W-1:0] r;
    logic found;
    r = WALK_FIRST;
    found = 1'b0;
    for (int i = 0; i < PTR_N; i++) begin
      if (!found && (i >= int'(v)) && on_walk(PTR_W'(i))) begin
        r = PTR_W'(i);
        found = 1'b1;
      end
    end
    return r;
  endfunction

  // next walk member strictly above p, wrapping to the first
  function automatic logic [PTR_W-1:0] walk_next(input logic [PTR_W-1:0] p);
    logic [PTR_W-1:0] r;
    logic found;
    r = WALK_FIRST;
    found = 1'b0;
    for (int i = 0; i < PTR_N; i++) begin
      if (!found && (i > int'(p)) && on_walk(PTR_W'(i))) begin
        r = PTR_W'(i);
        found = 1'b1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/bap_ptr.sv
module bap_ptr
  import blkacc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  output logic [PTR_W-1:0] ptr_q
);
  logic [PTR_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (step)      ptr_d = walk_next(ptr_q);
    else if (load) ptr_d = walk_ceil(load_val);
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= WALK_FIRST;
    else     ptr_q <= ptr_d;
  end

  AST_PTR_ON_WALK: assert property (@(posedge clk) disable iff (rst)
    on_walk(ptr_q)); // R4
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && ptr_q == WALK_LAST) |=> (ptr_q == WALK_FIRST)); // R4
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!step && !load) |=> $stable(ptr_q)); // R9
endmodule

// File: rtl/bap_xfer.sv
module bap_xfer
  import blkacc_pkg::*;
#(
  parameter int DW  = 8,
  parameter int TAW = 16,
  parameter logic [TAW-1:0] TGT_BASE = 16'h0500
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_wr,
  input  logic             acc_rd,
  input  logic             ptr_rd,
  input  logic [PTR_W-1:0] ptr_q,
  input  logic [DW-1:0]    wdata,
  output logic [TAW-1:0]   tgt_addr,
  output logic             tgt_wr,
  output logic             tgt_rd,
  output logic [DW-1:0]    tgt_wdata,
  input  logic [DW-1:0]    tgt_rdata,
  output logic [DW-1:0]    hst_rdata,
  output logic             hst_rvalid
);
  localparam int HI_W = TAW - PTR_W;
  localparam logic [HI_W-1:0] BASE_HI = TGT_BASE[TAW-1:PTR_W];

  logic             s1_ptr;
  logic [PTR_W-1:0] s1_val;

  // stage 1: target strobe / pointer capture
  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_wr    <= 1'b0;
      tgt_rd    <= 1'b0;
      tgt_addr  <= {BASE_HI, WALK_FIRST};
      tgt_wdata <= '0;
      s1_ptr    <= 1'b0;
      s1_val    <= WALK_FIRST;
    end else begin
      tgt_wr <= acc_wr;
      tgt_rd <= acc_rd;
      s1_ptr <= ptr_rd;
      s1_val <= ptr_q;
      if (acc_wr || acc_rd) tgt_addr <= {BASE_HI, ptr_q};
      if (acc_wr) tgt_wdata <= wdata;
    end
  end

  // stage 2: host read return
  always_ff @(posedge clk) begin
    if (rst) begin
      hst_rvalid <= 1'b0;
      hst_rdata  <= '0;
    end else begin
      hst_rvalid <= tgt_rd || s1_ptr;
      if (tgt_rd)      hst_rdata <= tgt_rdata;
      else if (s1_ptr) hst_rdata <= {{(DW-PTR_W){1'b0}}, s1_val};
    end
  end

  AST_TGT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(tgt_wr && tgt_rd)); // R10
  AST_RD_RETURN: assert property (@(posedge clk) disable iff (rst)
    tgt_rd |=> hst_rvalid); // R3
  AST_RD_DATA: assert property (@(posedge clk) disable iff (rst)
    tgt_rd |=> (hst_rdata == $past(tgt_rdata))); // R3
  AST_ADDR_HI: assert property (@(posedge clk) disable iff (rst)
    (tgt_wr || tgt_rd) |-> (tgt_addr[TAW-1:PTR_W] == BASE_HI)); // R7
  AST_ADDR_WALK: assert property (@(posedge clk) disable iff (rst)
    (tgt_wr || tgt_rd) |-> on_walk(tgt_addr[PTR_W-1:0])); // R4
endmodule

// File: rtl/bap_dreq.sv
module bap_dreq #(
  parameter int HAW = 16,
  parameter logic [HAW-1:0] ACC_ADDR = 16'h0100
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tmr_req,
  input  logic [HAW-1:0] dma_dst,
  output logic           dma_req
);
  always_ff @(posedge clk) begin
    if (rst) dma_req <= 1'b0;
    else     dma_req <= tmr_req && (dma_dst == ACC_ADDR);
  end

  AST_DREQ_SRC: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> $past(tmr_req)); // R8
endmodule

// File: rtl/blkacc_port.sv
module blkacc_port
  import blkacc_pkg::*;
#(
  parameter int HAW = 16,
  parameter int DW  = 8,
  parameter int TAW = 16,
  parameter logic [HAW-1:0] ACC_ADDR = 16'h0100,
  parameter logic [HAW-1:0] PTR_ADDR = 16'h0101,
  parameter logic [TAW-1:0] TGT_BASE = 16'h0500
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [HAW-1:0] hst_addr,
  input  logic           hst_we,
  input  logic           hst_re,
  input  logic [DW-1:0]  hst_wdata,
  output logic [DW-1:0]  hst_rdata,
  output logic           hst_rvalid,
  output logic [TAW-1:0] tgt_addr,
  output logic           tgt_wr,
  output logic           tgt_rd,
  output logic [DW-1:0]  tgt_wdata,
  input  logic [DW-1:0]  tgt_rdata,
  input  logic           tmr_req,
  input  logic [HAW-1:0] dma_dst,
  output logic           dma_req
);
  logic hit_acc, hit_ptr, do_wr, do_rd;
  logic acc_wr, acc_rd, ptr_wr, ptr_rd;
  logic [PTR_W-1:0] ptr_q;

  always_comb begin
    hit_acc = (hst_addr == ACC_ADDR);
    hit_ptr = (hst_addr == PTR_ADDR);
    do_wr   = hst_we;
    do_rd   = hst_re && !hst_we;
    acc_wr  = hit_acc && do_wr;
    acc_rd  = hit_acc && do_rd;
    ptr_wr  = hit_ptr && do_wr;
    ptr_rd  = hit_ptr && do_rd;
  end

  bap_ptr u_ptr (
    .clk      (clk),
    .rst      (rst),
    .step     (acc_wr || acc_rd),
    .load     (ptr_wr),
    .load_val (hst_wdata[PTR_W-1:0]),
    .ptr_q    (ptr_q)
  );

  bap_xfer #(.DW(DW), .TAW(TAW), .TGT_BASE(TGT_BASE)) u_xfer (
    .clk        (clk),
    .rst        (rst),
    .acc_wr     (acc_wr),
    .acc_rd     (acc_rd),
    .ptr_rd     (ptr_rd),
    .ptr_q      (ptr_q),
    .wdata      (hst_wdata),
    .tgt_addr   (tgt_addr),
    .tgt_wr     (tgt_wr),
    .tgt_rd     (tgt_rd),
    .tgt_wdata  (tgt_wdata),
    .tgt_rdata  (tgt_rdata),
    .hst_rdata  (hst_rdata),
    .hst_rvalid (hst_rvalid)
  );

  bap_dreq #(.HAW(HAW), .ACC_ADDR(ACC_ADDR)) u_dreq (
    .clk     (clk),
    .rst     (rst),
    .tmr_req (tmr_req),
    .dma_dst (dma_dst),
    .dma_req (dma_req)
  );

  AST_NO_STRAY_STROBE: assert property (@(posedge clk) disable iff (rst)
    (!(hst_we || hst_re) || !(hit_acc || hit_ptr)) |=> (!tgt_wr && !tgt_rd)); // R9
  AST_PTRWR_QUIET: assert property (@(posedge clk) disable iff (rst)
    ptr_wr |=> !tgt_wr && !tgt_rd); // R5
endmodule

// File: tb/sim_blkacc_port.sv
`timescale 1ns/1ps
module sim_blkacc_port;
  localparam int ACC = 16'h0100;
  localparam int PTR = 16'h0101;
  localparam int BASE = 16'h0500;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] hst_addr = '0;
  logic hst_we = 1'b0, hst_re = 1'b0;
  logic [7:0] hst_wdata = '0;
  logic [7:0] hst_rdata;
  logic hst_rvalid;
  logic [15:0] tgt_addr;
  logic tgt_wr, tgt_rd;
  logic [7:0] tgt_wdata;
  logic [7:0] tgt_rdata;
  logic tmr_req = 1'b0;
  logic [15:0] dma_dst = '0;
  logic dma_req;

  always #2 clk = ~clk;

  function automatic logic [7:0] tdat(input int a);
    return 8'((a * 37 + 11) ^ 8'hA5);
  endfunction
  assign tgt_rdata = tdat(int'(tgt_addr));

  blkacc_port u0 (.*);

  int seq [18] = '{2, 3, 8, 9, 10, 11, 12, 13, 14, 15, 24, 25, 26, 27, 28, 29, 30, 31};
  function automatic int m_next(input int p);
    for (int i = 0; i < 18; i++) if (seq[i] == p) return seq[(i + 1) % 18];
    return -1;
  endfunction
  function automatic int m_ceil(input int v);
    for (int i = 0; i < 18; i++) if (seq[i] >= v) return seq[i];
    return seq[0];
  endfunction

  int vectors = 0, miscompares = 0;
  string phase = "R1";
  bit started = 0;

  // reference model state
  int m_ptr = 2;
  bit e_tw = 0, e_tr = 0, e_rv = 0, e_dma = 0, e_s1p = 0, e_rvptr = 0;
  int e_taddr = BASE + 2, e_twd = 0, e_rd = 0, e_s1v = 2;

  always @(posedge clk) begin
    bit aw, ar, pw, pr;
    started = 1;
    if (rst) begin
      m_ptr = 2; e_tw = 0; e_tr = 0; e_rv = 0; e_dma = 0; e_s1p = 0;
    end else begin
      e_rv = e_tr || e_s1p;
      e_rvptr = e_s1p && !e_tr;
      if (e_tr) e_rd = tdat(e_taddr);
      else if (e_s1p) e_rd = e_s1v;
      aw = hst_we && hst_addr == ACC;
      ar = hst_re && !hst_we && hst_addr == ACC;
      pw = hst_we && hst_addr == PTR;
      pr = hst_re && !hst_we && hst_addr == PTR;
      e_tw = aw; e_tr = ar;
      if (aw || ar) e_taddr = BASE + m_ptr;
      if (aw) e_twd = hst_wdata;
      e_s1p = pr; e_s1v = m_ptr;
      if (aw || ar) m_ptr = m_next(m_ptr);
      else if (pw) m_ptr = m_ceil(hst_wdata & 31);
      e_dma = tmr_req && dma_dst == ACC;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s (phase %s) t=%0t actual=%0h expected=%0h", tag, phase, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (started) begin
    chk(rst ? "R1 tgt_wr" : "R2 tgt_wr", int'(tgt_wr), int'(e_tw));
    chk(rst ? "R1 tgt_rd" : "R3 tgt_rd", int'(tgt_rd), int'(e_tr));
    chk(rst ? "R1 hst_rvalid" : "R3 hst_rvalid", int'(hst_rvalid), int'(e_rv));
    chk(rst ? "R1 dma_req" : "R8 dma_req", int'(dma_req), int'(e_dma));
    if (tgt_wr || tgt_rd) begin
      chk("R4 tgt_addr low", int'(tgt_addr[4:0]), e_taddr & 31);
      chk("R7 tgt_addr high", int'(tgt_addr[15:5]), e_taddr >> 5);
    end
    if (tgt_wr) chk("R2 tgt_wdata", int'(tgt_wdata), e_twd);
    if (hst_rvalid) chk(e_rvptr ? "R6 ptr readback" : "R3 hst_rdata", int'(hst_rdata), e_rd);
  end

  task automatic op(input bit we, input bit re, input int a, input int d);
    @(negedge clk);
    hst_we = we; hst_re = re; hst_addr = 16'(a); hst_wdata = 8'(d);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op(0, 0, 0, 0);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    phase = "R1";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(2);
    phase = "R6";
    op(0, 1, PTR, 0); idle(3);
    phase = "R2";
    for (int i = 0; i < 20; i++) op(1, 0, ACC, 8'h30 + i);
    op(0, 1, PTR, 0); idle(3);
    phase = "R3";
    for (int i = 0; i < 18; i++) op(0, 1, ACC, 0);
    for (int i = 0; i < 6; i++) begin op(0, 1, ACC, 0); op(0, 1, PTR, 0); end
    idle(3);
    phase = "R5";
    foreach (seq[k]) begin end
    begin
      int vals [10] = '{0, 1, 4, 7, 16, 23, 31, 10, 3, 255};
      foreach (vals[k]) begin
        op(1, 0, PTR, vals[k]);
        op(0, 1, PTR, 0);
        op(1, 0, ACC, vals[k] + 1);
        op(0, 1, PTR, 0);
      end
    end
    idle(3);
    phase = "R9";
    op(1, 0, 16'h0102, 8'h55); op(0, 1, 16'h00FF, 0); op(1, 1, 16'h0200, 8'h04);
    op(0, 1, PTR, 0); idle(3);
    phase = "R10";
    op(1, 1, ACC, 8'h77); op(1, 1, PTR, 8'h11); op(0, 1, PTR, 0);
    op(1, 1, ACC, 8'h78); op(0, 1, ACC, 0); idle(3);
    phase = "R8";
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      tmr_req = (i % 3) != 1;
      dma_dst = (i % 4 == 2) ? 16'h0101 : 16'(ACC);
      hst_we = (i % 2 == 0); hst_re = (i % 2 == 1); hst_addr = 16'(ACC); hst_wdata = 8'(i);
    end
    @(negedge clk); tmr_req = 0; hst_we = 0; hst_re = 0;
    phase = "R4";
    op(1, 0, PTR, 8'h1E);
    for (int i = 0; i < 40; i++) op(i % 3 == 0, i % 3 != 0, ACC, i);
    op(0, 1, PTR, 0); idle(3);
    phase = "R1";
    @(negedge clk); rst = 1'b1; op(1, 0, ACC, 1); idle(2);
    rst = 1'b0; op(0, 1, PTR, 0); idle(3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule